// File: doc/BRIEF.md
# PWM Generator with Shadowed Update Handshake

This block produces one pulse-width-modulated output from a 22-bit phase accumulator. On every running clock the accumulator advances by a fixed-point step that has an 8-bit integer part and a 14-bit fraction. The output frequency is therefore clk × step / 2^22. The duty cycle is set by an 8-bit threshold that is compared against the top eight accumulator bits.

Software uses a single 32-bit register. A write always lands in shadow copies of the step and the threshold. The shadow copies reach the running generator only when software also raises a request bit in the same write. The copy then happens at the next period boundary, and the block clears the request bit at that moment. A write that changes the shadow settings while a request is still outstanding locks the block into a frozen state that only reset leaves. A request that would change nothing is dropped at once. Enabling follows a fixed order: raise the request bit first, then set the enable bit with the same settings.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: The register word is laid out as follows:
  - bit 31 is the enable bit;
  - bit 30 is the request (update) bit;
  - bits 29:8 hold the step, with bits 29:22 as the integer part and bits 21:8 as the fraction;
  - bits 7:0 hold the threshold.
  
  A read returns the live enable bit, the outstanding request bit and the shadow step and threshold.
- R2: Reset clears the live and shadow fields, the request bit and the frozen state. The output is low after reset.
- R3: While running, a period lasts 2^22/step clocks. In each cycle the output is high exactly when the top 8 accumulator bits are strictly greater than the live threshold, and the accumulator starts each enable at zero.
- R4: A live threshold of 255 holds the output constantly low (0% duty).
- R5: A write without the request bit changes the shadow fields but does not change the output.
- R6: An outstanding request is consumed at a period boundary. At that boundary the shadow fields are copied to the live fields and the request bit clears. A boundary is either the first clock after enable or the clock on which the accumulator wraps.
- R7: While disabled, the output is low, no boundary occurs, and an outstanding request stays set.
- R8: With a request outstanding, a write that repeats the same step and threshold (for example to set the enable bit) is accepted and causes no freeze.
- R9: A write that changes the step or the threshold while a request is outstanding and not being consumed freezes the block. While frozen:
  - the live fields and the live enable never change again;
  - the request bit stays set;
  - later writes still update the shadow fields but have no effect on the output.
- R10: A write with the request bit set whose step and threshold equal the values about to be live is dropped, so the request bit stays clear. A later request with changed values is applied normally.
- R11: A written step whose integer part is 128 or more is stored as the largest valid step, 22'h1FFFFF.
- R12: A write that arrives in the same cycle a boundary consumes a request is not a freeze. Its own request, if its values differ from the newly loaded live values, becomes the next outstanding request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| pwm_o | output | 1 | PWM output |

## Verification
The sharpest collision is a register write landing on the very clock that a period boundary consumes an outstanding request. That cycle decides between a legal new request and a freeze. The bench provokes it by issuing three back-to-back writes: a request while disabled, an enable with the same settings, and a changed request. The third write then falls exactly on the start boundary. The bench judges the result by observing three things: the request bit is still set right afterwards, it clears one period later, and the measured duty matches the third write's threshold rather than a frozen output.

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl #(
  parameter int BU_INT_W  = 8,
  parameter int BU_FRAC_W = 14,
  parameter int DIV_W     = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [2+BU_INT_W+BU_FRAC_W+DIV_W-1:0] wr_data,
  output logic [2+BU_INT_W+BU_FRAC_W+DIV_W-1:0] rd_data,
  output logic                               pwm_o
);
  localparam int BU_W  = BU_INT_W + BU_FRAC_W;
  localparam int REG_W = 2 + BU_W + DIV_W;
  localparam logic [BU_W-1:0] BU_MAX = {1'b0, {(BU_W-1){1'b1}}};

  logic             en_q, run_q, pend_q, frozen_q;
  logic [BU_W-1:0]  acc_q, bu_lv, bu_sh;
  logic [DIV_W-1:0] div_lv, div_sh;

  logic             wr_en_bit, wr_upd;
  logic [BU_W-1:0]  wr_bu_raw, wr_bu;
  logic [DIV_W-1:0] wr_div;
  assign wr_en_bit = wr_data[REG_W-1];
  assign wr_upd    = wr_data[REG_W-2];
  assign wr_bu_raw = wr_data[DIV_W +: BU_W];
  assign wr_div    = wr_data[DIV_W-1:0];
  assign wr_bu     = wr_bu_raw[BU_W-1] ? BU_MAX : wr_bu_raw;

  logic [BU_W:0] sum;
  assign sum = {1'b0, acc_q} + {1'b0, bu_lv};

  logic boundary, consume, clash, changed, wr_ok;
  logic [BU_W-1:0]  bu_nx;
  logic [DIV_W-1:0] div_nx;
  assign boundary = en_q & (~run_q | sum[BU_W]);
  assign consume  = boundary & pend_q & ~frozen_q;
  assign bu_nx    = consume ? bu_sh  : bu_lv;
  assign div_nx   = consume ? div_sh : div_lv;
  assign clash    = wr_en & pend_q & ~consume & ~frozen_q &
                    ((wr_bu != bu_sh) | (wr_div != div_sh));
  assign changed  = (wr_bu != bu_nx) | (wr_div != div_nx);
  assign wr_ok    = wr_en & ~frozen_q & ~clash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      frozen_q <= 1'b0;
      acc_q    <= '0;
      bu_lv    <= '0;
      bu_sh    <= '0;
      div_lv   <= '0;
      div_sh   <= '0;
    end else begin
      frozen_q <= frozen_q | clash;
      run_q    <= en_q;
      if (!en_q || !run_q) acc_q <= '0;
      else                 acc_q <= sum[BU_W-1:0];
      bu_lv  <= bu_nx;
      div_lv <= div_nx;
      if (wr_en) begin
        bu_sh  <= wr_bu;
        div_sh <= wr_div;
      end
      if (wr_ok) en_q <= wr_en_bit;
      if (wr_ok && wr_upd && changed) pend_q <= 1'b1;
      else if (consume)               pend_q <= 1'b0;
    end
  end

  assign rd_data = {en_q, pend_q, bu_sh, div_sh};
  assign pwm_o   = en_q & run_q & (acc_q[BU_W-1 -: DIV_W] > div_lv);
endmodule

// File: rtl/pwm_shadow_ctrl_chk.sv
module pwm_shadow_ctrl_chk #(
  parameter int BU_W  = 22,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_top,
  input logic             en_q,
  input logic             pend_q,
  input logic             frozen_q,
  input logic             boundary,
  input logic [BU_W-1:0]  bu_lv,
  input logic [BU_W-1:0]  bu_sh,
  input logic [DIV_W-1:0] div_lv,
  input logic             pwm_o
);
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_o);
  p_hold_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !en_q) |=> pend_q);
  p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_lv == '1) |-> !pwm_o);
  p_sticky_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> frozen_q);
  p_frozen_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> ($stable(bu_lv) && $stable(div_lv) && $stable(en_q)));
  p_live_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(bu_lv) && $stable(div_lv)));
  p_clear_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && pend_q && !frozen_q && !wr_en) |=> !pend_q);
  p_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_top) |=> (bu_sh == {1'b0, {(BU_W-1){1'b1}}}));
endmodule

bind pwm_shadow_ctrl pwm_shadow_ctrl_chk #(.BU_W(BU_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_top(wr_bu_raw[BU_W-1]),
  .en_q(en_q), .pend_q(pend_q), .frozen_q(frozen_q), .boundary(boundary),
  .bu_lv(bu_lv), .bu_sh(bu_sh), .div_lv(div_lv), .pwm_o(pwm_o)
);

// File: tb/tb_pwm_shadow_ctrl.sv
module tb_pwm_shadow_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_o;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_shadow_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                       .rd_data(rd_data), .pwm_o(pwm_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] cfg(bit en, bit upd, int bi, int d);
    cfg = {en, upd, bi[7:0], 14'd0, d[7:0]};
  endfunction

  function automatic int exp_high(int bi, int d);
    int n = 256 / bi;
    int c = 0;
    for (int k = 0; k < n; k++) if (k * bi > d) c++;
    return c;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_clear(int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (!rd_data[30]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure(int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      if (pwm_o) highs++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic apply_check(int bi, int d, string req);
    bit ok;
    int h;
    wr(cfg(1, 1, bi, d));
    wait_clear(600, ok);
    check(ok, req, int'(rd_data[30]), 0);
    idle(256 / bi);
    measure(2 * (256 / bi), h);
    check(h == 2 * exp_high(bi, d), req, h, 2 * exp_high(bi, d));
  endtask

  initial begin
    bit ok;
    int h;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 32'd0, "R2 reset readback", int'(rd_data), 0);
    check(pwm_o == 1'b0, "R2 reset output", int'(pwm_o), 0);

    wr(cfg(0, 1, 16, 100));
    measure(300, h);
    check(h == 0, "R7 disabled output", h, 0);
    check(rd_data[30] == 1'b1, "R7 pending held", int'(rd_data[30]), 1);
    check(rd_data == cfg(0, 1, 16, 100), "R1 readback layout", int'(rd_data), int'(cfg(0, 1, 16, 100)));

    wr(cfg(1, 0, 16, 100));
    @(negedge clk);
    check(rd_data[30] == 1'b0, "R6 R8 consumed at enable", int'(rd_data[30]), 1'b0);
    check(rd_data[31] == 1'b1, "R1 enable readback", int'(rd_data[31]), 1);
    idle(32);
    measure(32, h);
    check(h == 2 * exp_high(16, 100), "R3 first duty", h, 2 * exp_high(16, 100));

    for (int s = 0; s < 7; s++) begin
      int dv[5] = '{0, 37, 128, 200, 254};
      for (int j = 0; j < 5; j++) apply_check(1 << s, dv[j], "R3 sweep");
    end

    apply_check(4, 255, "R4 zero duty");
    apply_check(1, 255, "R4 zero duty slow");

    apply_check(8, 50, "R5 setup");
    wr(cfg(1, 0, 8, 200));
    idle(40);
    measure(64, h);
    check(h == 2 * exp_high(8, 50), "R5 no request no effect", h, 2 * exp_high(8, 50));
    check(rd_data[7:0] == 8'd200, "R5 shadow written", int'(rd_data[7:0]), 200);
    check(rd_data[30] == 1'b0, "R5 no request raised", int'(rd_data[30]), 0);

    apply_check(8, 60, "R10 setup");
    wr(cfg(1, 1, 8, 60));
    check(rd_data[30] == 1'b0, "R10 redundant dropped", int'(rd_data[30]), 0);
    wr(cfg(1, 1, 8, 180));
    check(rd_data[30] == 1'b1, "R10 real request pending", int'(rd_data[30]), 1);
    wait_clear(100, ok);
    check(ok, "R10 request consumed", int'(rd_data[30]), 0);
    idle(32);
    measure(64, h);
    check(h == 2 * exp_high(8, 180), "R10 new duty applied", h, 2 * exp_high(8, 180));

    wr(cfg(1, 0, 200, 180));
    check(rd_data[29:8] == 22'h1FFFFF, "R11 clamp", int'(rd_data[29:8]), 32'h1FFFFF);
    measure(64, h);
    check(h == 2 * exp_high(8, 180), "R11 clamp write no output effect", h, 2 * exp_high(8, 180));

    apply_check(1, 128, "R9 setup");
    wr(cfg(1, 1, 2, 10));
    wr(cfg(1, 1, 4, 20));
    idle(600);
    check(rd_data[30] == 1'b1, "R9 frozen request stuck", int'(rd_data[30]), 1);
    measure(512, h);
    check(h == 2 * exp_high(1, 128), "R9 frozen output", h, 2 * exp_high(1, 128));
    wr(cfg(1, 1, 8, 30));
    wr(cfg(0, 0, 8, 30));
    check(rd_data[7:0] == 8'd30, "R9 shadow still written", int'(rd_data[7:0]), 30);
    check(rd_data[31] == 1'b1, "R9 enable held", int'(rd_data[31]), 1);
    idle(300);
    measure(512, h);
    check(h == 2 * exp_high(1, 128), "R9 later writes no effect", h, 2 * exp_high(1, 128));

    do_reset();
    check(rd_data == 32'd0, "R2 reset after freeze", int'(rd_data), 0);
    check(pwm_o == 1'b0, "R2 output after reset", int'(pwm_o), 0);
    wr(cfg(0, 1, 8, 40));
    wr(cfg(1, 1, 8, 40));
    wait_clear(20, ok);
    check(ok, "R8 same-field enable write", int'(rd_data[30]), 0);
    idle(32);
    measure(64, h);
    check(h == 2 * exp_high(8, 40), "R2 R8 freeze cleared", h, 2 * exp_high(8, 40));

    do_reset();
    wr(cfg(0, 1, 16, 70));
    wr(cfg(1, 0, 16, 70));
    wr(cfg(1, 1, 16, 190));
    check(rd_data[30] == 1'b1, "R12 collision request kept", int'(rd_data[30]), 1);
    wait_clear(40, ok);
    check(ok, "R12 collision not frozen", int'(rd_data[30]), 0);
    idle(16);
    measure(32, h);
    check(h == 2 * exp_high(16, 190), "R12 collision duty", h, 2 * exp_high(16, 190));

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule